// File: doc/BRIEF.md
# Hardware Cursor Overlay Compositor

This block lays a small ARGB cursor picture over a display pixel stream. The picture lives in a local RAM that a host fills through a word-addressed write port. Each incoming pixel carries its raster coordinates, relative to the active area, and a 24-bit base colour. The block answers two cycles later with either the base colour or the cursor colour mixed over it by the cursor alpha.

The host programs the cursor origin, its size and an enable request into shadow registers. These values reach the working copy only when the raster's frame-done pulse arrives, so a half-updated cursor never shows on screen. Changing the size, or programming a zero dimension, blanks the cursor at once. It stays blank until a new image has been written and a frame-done commits it. The picture RAM holds up to 2048 words in two banks, so either a 64-wide by 32-tall shape or a 32-wide by 64-tall shape fits.

A four-state controller owns the commit:
- **IDLE**: cursor off, nothing pending.
- **ARMED**: cursor off, update pending.
- **LIVE**: cursor on, nothing pending.
- **LIVE_ARMED**: cursor on, update pending.

Transitions:
- An accepted register write moves IDLE to ARMED and LIVE to LIVE_ARMED.
- A frame-done in either pending state commits. It goes to LIVE or IDLE, or to LIVE_ARMED or ARMED if a write lands in the same cycle.
- A size change or a zero dimension forces ARMED from any state.

Top module: `cursor_overlay`

## Requirements
- R1: After reset `cursor_on`, `upd_pending` and `out_valid` are low.
- R2: `out_valid` and `out_pix` follow `px_valid` and `px_base` two clock edges later. A pixel outside the live rectangle, or any pixel while the cursor is off, leaves with its base colour unchanged.
- R3: Writes to the origin (`pos_data`, x in bits 15:0, y in bits 31:16), size or enable set `upd_pending` on the next cycle. They do not alter the displayed cursor until a frame-done. `upd_pending` is low the cycle after that frame-done unless another write arrives with it.
- R4: At a committing frame-done the cursor turns on only if all of the following hold: enable was requested, an image word has been written since the last size change, and both dimensions are non-zero. `cursor_on` never rises on any other cycle.
- R5: A size write (`size_data`, w in bits 15:0, h in bits 31:16) is rejected when w or h exceeds 64, or when both exceed 32. A rejected write changes neither `upd_pending` nor `cursor_on`.
- R6: An accepted size write with a zero dimension, or one differing from the committed size, clears `cursor_on` on the next cycle. It also marks the image as not loaded.
- R7: When `interlace` is high at the committing frame-done, the live y origin and height are halved (shift right by one).
- R8: A written word {A,R,G,B} (A in bits 31:24) is stored with bits 23:16 and 7:0 exchanged. The stream colour is {B,G,R}, so an opaque cursor pixel leaves as {wdata[7:0], wdata[15:8], wdata[23:16]}.
- R9: With alpha 255 the cursor colour leaves, and with alpha 0 the base colour leaves. Otherwise each channel is (c*a + b*(256-a)) >> 8.
- R10: The cursor pixel at column c, row r reads image word r*w + c. Words 0..1023 sit in the first bank and 1024..2047 in the second.
- R11: An enable write of 0 turns the cursor off only at the next frame-done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| interlace | input | 1 | Interlaced raster; sampled at commit |
| frame_done | input | 1 | One-cycle end-of-frame pulse |
| pos_wr | input | 1 | Origin shadow write strobe |
| pos_data | input | 32 | y in 31:16, x in 15:0 |
| size_wr | input | 1 | Size shadow write strobe |
| size_data | input | 32 | h in 31:16, w in 15:0 |
| en_wr | input | 1 | Enable request write strobe |
| en_data | input | 1 | Enable request value |
| pix_we | input | 1 | Image word write strobe |
| pix_addr | input | 11 | Image word index |
| pix_wdata | input | 32 | ARGB image word |
| px_valid | input | 1 | Stream pixel present |
| px_x | input | 16 | Pixel column in active area |
| px_y | input | 16 | Pixel line in active area |
| px_base | input | 24 | Base colour {B,G,R} |
| out_valid | output | 1 | Output pixel present |
| out_pix | output | 24 | Composited colour {B,G,R} |
| cursor_on | output | 1 | Working-copy cursor enable |
| upd_pending | output | 1 | Shadow values await a frame-done |

## Verification
Each pixel result is due on the second rising edge after the pixel is presented, and each change of `cursor_on` or `upd_pending` is due on the first edge after the write or frame-done that causes it. Inputs change on falling edges. A behavioural model advances on every rising edge with the same register counts, and both are compared on every falling edge. Directed probes drive a single pixel and read the answer two falling edges later. State checks read the status outputs one falling edge after the triggering strobe.

// File: rtl/cur_pkg.sv
`timescale 1ns/1ps
package cur_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_ARMED      = 2'd1,
        ST_LIVE       = 2'd2,
        ST_LIVE_ARMED = 2'd3
    } cur_state_e;

    function automatic cur_state_e pick_state(logic on, logic pend);
        if (on)
            return pend ? ST_LIVE_ARMED : ST_LIVE;
        return pend ? ST_ARMED : ST_IDLE;
    endfunction

    // host word {A,R,G,B} -> stored {A,B,G,R}
    function automatic logic [31:0] swap_rb(logic [31:0] d);
        return {d[31:24], d[7:0], d[15:8], d[23:16]};
    endfunction

    function automatic logic [7:0] mix_ch(logic [7:0] c, logic [7:0] b, logic [7:0] a);
        logic [15:0] s;
        if (a == 8'hFF)
            return c;
        if (a == 8'h00)
            return b;
        s = 16'(c) * 16'(a) + 16'(b) * (16'd256 - 16'(a));
        return 8'(s >> 8);
    endfunction

endpackage

// File: rtl/cur_shadow.sv
`timescale 1ns/1ps
module cur_shadow
    import cur_pkg::*;
#(
    parameter int MAX_LONG  = 64,
    parameter int MAX_SHORT = 32,
    parameter int SW        = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          interlace,
    input  logic          frame_done,
    input  logic          pos_wr,
    input  logic [31:0]   pos_data,
    input  logic          size_wr,
    input  logic [31:0]   size_data,
    input  logic          en_wr,
    input  logic          en_data,
    input  logic          pix_we,
    output logic [15:0]   live_x,
    output logic [15:0]   live_y,
    output logic [SW-1:0] live_w,
    output logic [SW-1:0] live_h,
    output logic          cursor_on,
    output logic          upd_pending
);

    localparam logic [15:0] LONG_LIM  = 16'(MAX_LONG);
    localparam logic [15:0] SHORT_LIM = 16'(MAX_SHORT);

    cur_state_e state_q, state_d;

    logic [15:0]   pend_x, pend_y;
    logic [SW-1:0] pend_w, pend_h;
    logic          pend_en;
    logic [SW-1:0] raw_w, raw_h;
    logic          img_ok;

    logic [15:0] req_w, req_h;
    logic        size_ok, any_wr, kill, commit_on;

    assign req_w = size_data[15:0];
    assign req_h = size_data[31:16];

    assign size_ok = !((req_w > LONG_LIM) || (req_h > LONG_LIM) ||
                       ((req_w > SHORT_LIM) && (req_h > SHORT_LIM)));
    assign any_wr  = pos_wr || en_wr || (size_wr && size_ok);
    assign kill    = size_wr && size_ok &&
                     ((req_w == 16'd0) || (req_h == 16'd0) ||
                      (req_w != 16'(raw_w)) || (req_h != 16'(raw_h)));
    assign commit_on = pend_en && img_ok && (pend_w != '0) && (pend_h != '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (any_wr)
                    state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (frame_done)
                    state_d = pick_state(commit_on && !kill, any_wr);
            end
            ST_LIVE: begin
                if (kill)
                    state_d = ST_ARMED;
                else if (any_wr)
                    state_d = ST_LIVE_ARMED;
            end
            ST_LIVE_ARMED: begin
                if (frame_done)
                    state_d = pick_state(commit_on && !kill, any_wr);
                else if (kill)
                    state_d = ST_ARMED;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // outputs decoded from state
    always_comb begin
        cursor_on   = 1'b0;
        upd_pending = 1'b0;
        unique case (state_q)
            ST_IDLE:       begin cursor_on = 1'b0; upd_pending = 1'b0; end
            ST_ARMED:      begin cursor_on = 1'b0; upd_pending = 1'b1; end
            ST_LIVE:       begin cursor_on = 1'b1; upd_pending = 1'b0; end
            ST_LIVE_ARMED: begin cursor_on = 1'b1; upd_pending = 1'b1; end
            default:       begin cursor_on = 1'b0; upd_pending = 1'b0; end
        endcase
    end

    // shadow registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_x  <= '0;
            pend_y  <= '0;
            pend_w  <= '0;
            pend_h  <= '0;
            pend_en <= 1'b0;
        end else begin
            if (pos_wr) begin
                pend_x <= pos_data[15:0];
                pend_y <= pos_data[31:16];
            end
            if (size_wr && size_ok) begin
                pend_w <= SW'(req_w);
                pend_h <= SW'(req_h);
            end
            if (en_wr)
                pend_en <= en_data;
        end
    end

    // working copy, loaded at a committing frame-done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_x <= '0;
            live_y <= '0;
            live_w <= '0;
            live_h <= '0;
            raw_w  <= '0;
            raw_h  <= '0;
        end else if (frame_done && upd_pending) begin
            live_x <= pend_x;
            live_y <= interlace ? (pend_y >> 1) : pend_y;
            live_w <= pend_w;
            live_h <= interlace ? (pend_h >> 1) : pend_h;
            raw_w  <= pend_w;
            raw_h  <= pend_h;
        end
    end

    // image-loaded tracking
    always_ff @(posedge clk) begin
        if (!rst_n)
            img_ok <= 1'b0;
        else if (kill)
            img_ok <= 1'b0;
        else if (pix_we)
            img_ok <= 1'b1;
    end

endmodule

// File: rtl/cur_image_ram.sv
`timescale 1ns/1ps
module cur_image_ram #(
    parameter int DEPTH = 2048,
    parameter int BANKS = 2,
    parameter int DW    = 32
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [DW-1:0]            rdata
);

    localparam int AW = $clog2(DEPTH);
    localparam int BD = DEPTH / BANKS;
    localparam int OW = $clog2(BD);
    localparam int BW = AW - OW;

    logic [BANKS-1:0][DW-1:0] bank_q;
    logic [BW-1:0]            rsel;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [DW-1:0] mem [BD];
        logic [DW-1:0] q;

        always_ff @(posedge clk) begin
            if (we && (waddr[AW-1:OW] == BW'(b)))
                mem[waddr[OW-1:0]] <= wdata;
            q <= mem[raddr[OW-1:0]];
        end

        assign bank_q[b] = q;
    end

    always_ff @(posedge clk)
        rsel <= raddr[AW-1:OW];

    assign rdata = bank_q[rsel];

endmodule

// File: rtl/cur_blend.sv
`timescale 1ns/1ps
module cur_blend
    import cur_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_hit,
    input  logic [23:0] in_base,
    input  logic [31:0] cur_q,
    output logic        out_valid,
    output logic [23:0] out_pix
);

    logic        v1, hit1;
    logic [23:0] base1;
    logic [23:0] mixed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1    <= 1'b0;
            hit1  <= 1'b0;
            base1 <= '0;
        end else begin
            v1    <= in_valid;
            hit1  <= in_hit;
            base1 <= in_base;
        end
    end

    for (genvar c = 0; c < 3; c++) begin : g_ch
        assign mixed[8*c +: 8] = mix_ch(cur_q[8*c +: 8], base1[8*c +: 8], cur_q[31:24]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= v1;
            out_pix   <= hit1 ? mixed : base1;
        end
    end

endmodule

// File: rtl/cursor_overlay.sv
`timescale 1ns/1ps
module cursor_overlay
    import cur_pkg::*;
#(
    parameter int MAX_LONG  = 64,
    parameter int MAX_SHORT = 32,
    parameter int BANKS     = 2,
    localparam int DEPTH    = MAX_LONG * MAX_SHORT,
    localparam int AW       = $clog2(DEPTH),
    localparam int SW       = $clog2(MAX_LONG) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          interlace,
    input  logic          frame_done,
    input  logic          pos_wr,
    input  logic [31:0]   pos_data,
    input  logic          size_wr,
    input  logic [31:0]   size_data,
    input  logic          en_wr,
    input  logic          en_data,
    input  logic          pix_we,
    input  logic [AW-1:0] pix_addr,
    input  logic [31:0]   pix_wdata,
    input  logic          px_valid,
    input  logic [15:0]   px_x,
    input  logic [15:0]   px_y,
    input  logic [23:0]   px_base,
    output logic          out_valid,
    output logic [23:0]   out_pix,
    output logic          cursor_on,
    output logic          upd_pending
);

    logic [15:0]   live_x, live_y;
    logic [SW-1:0] live_w, live_h;
    logic [16:0]   x_end, y_end;
    logic          hit;
    logic [AW-1:0] rd_idx;
    logic [31:0]   cur_q;

    cur_shadow #(
        .MAX_LONG (MAX_LONG),
        .MAX_SHORT(MAX_SHORT),
        .SW       (SW)
    ) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .interlace  (interlace),
        .frame_done (frame_done),
        .pos_wr     (pos_wr),
        .pos_data   (pos_data),
        .size_wr    (size_wr),
        .size_data  (size_data),
        .en_wr      (en_wr),
        .en_data    (en_data),
        .pix_we     (pix_we),
        .live_x     (live_x),
        .live_y     (live_y),
        .live_w     (live_w),
        .live_h     (live_h),
        .cursor_on  (cursor_on),
        .upd_pending(upd_pending)
    );

    // rectangle test and image index
    assign x_end = {1'b0, live_x} + 17'(live_w);
    assign y_end = {1'b0, live_y} + 17'(live_h);
    assign hit   = cursor_on && px_valid &&
                   (px_x >= live_x) && ({1'b0, px_x} < x_end) &&
                   (px_y >= live_y) && ({1'b0, px_y} < y_end);
    assign rd_idx = AW'(AW'(px_y - live_y) * AW'(live_w) + AW'(px_x - live_x));

    cur_image_ram #(
        .DEPTH(DEPTH),
        .BANKS(BANKS),
        .DW   (32)
    ) u_ram (
        .clk  (clk),
        .we   (pix_we),
        .waddr(pix_addr),
        .wdata(swap_rb(pix_wdata)),
        .raddr(rd_idx),
        .rdata(cur_q)
    );

    cur_blend u_blend (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (px_valid),
        .in_hit   (hit),
        .in_base  (px_base),
        .cur_q    (cur_q),
        .out_valid(out_valid),
        .out_pix  (out_pix)
    );

endmodule

// File: rtl/cursor_overlay_chk.sv
`timescale 1ns/1ps
module cursor_overlay_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        frame_done,
    input logic        pos_wr,
    input logic        size_wr,
    input logic [31:0] size_data,
    input logic        en_wr,
    input logic        px_valid,
    input logic        out_valid,
    input logic        cursor_on,
    input logic        upd_pending
);

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid |=> ##1 out_valid);

    assert_latency_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !px_valid |=> ##1 !out_valid);

    assert_pend_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && upd_pending && !pos_wr && !size_wr && !en_wr) |=> !upd_pending);

    assert_on_at_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cursor_on) |-> $past(frame_done));

    assert_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (size_wr && size_data[15:0] > 16'd32 && size_data[31:16] > 16'd32 &&
         !pos_wr && !en_wr && !frame_done) |=> ($stable(upd_pending) && $stable(cursor_on)));

    assert_kill_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (size_wr && (size_data[15:0] == 16'd0 || size_data[31:16] == 16'd0) &&
         size_data[15:0] <= 16'd64 && size_data[31:16] <= 16'd64) |=> !cursor_on);

endmodule

bind cursor_overlay cursor_overlay_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_done (frame_done),
    .pos_wr     (pos_wr),
    .size_wr    (size_wr),
    .size_data  (size_data),
    .en_wr      (en_wr),
    .px_valid   (px_valid),
    .out_valid  (out_valid),
    .cursor_on  (cursor_on),
    .upd_pending(upd_pending)
);

// File: tb/test_cursor_overlay.sv
`timescale 1ns/1ps
module test_cursor_overlay;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        interlace = 1'b0, frame_done = 1'b0;
    logic        pos_wr = 1'b0, size_wr = 1'b0, en_wr = 1'b0, en_data = 1'b0;
    logic [31:0] pos_data = '0, size_data = '0;
    logic        pix_we = 1'b0;
    logic [10:0] pix_addr = '0;
    logic [31:0] pix_wdata = '0;
    logic        px_valid = 1'b0;
    logic [15:0] px_x = '0, px_y = '0;
    logic [23:0] px_base = '0;
    logic        out_valid, cursor_on, upd_pending;
    logic [23:0] out_pix;

    int    n_checks = 0, n_fails = 0;
    string phase = "R1";

    always #5 clk = ~clk;

    cursor_overlay i_cursor_overlay (
        .clk(clk), .rst_n(rst_n), .interlace(interlace), .frame_done(frame_done),
        .pos_wr(pos_wr), .pos_data(pos_data), .size_wr(size_wr), .size_data(size_data),
        .en_wr(en_wr), .en_data(en_data), .pix_we(pix_we), .pix_addr(pix_addr),
        .pix_wdata(pix_wdata), .px_valid(px_valid), .px_x(px_x), .px_y(px_y),
        .px_base(px_base), .out_valid(out_valid), .out_pix(out_pix),
        .cursor_on(cursor_on), .upd_pending(upd_pending)
    );

    // ---------------- behavioural reference ----------------
    logic [31:0] mmem [2048];
    bit          m_on, m_pend, m_img, p_en;
    int          p_x, p_y, p_w, p_h, l_x, l_y, l_w, l_h, l_rw, l_rh;
    bit          s_v, s_hit, o_v;
    logic [23:0] s_base, o_pix;
    logic [31:0] s_cur;
    int          mw, mh;
    bit          m_ok, m_any, m_kill, m_commit;

    function automatic logic [23:0] mblend(logic [31:0] cw, logic [23:0] b);
        logic [23:0] r;
        int a;
        a = int'(cw[31:24]);
        for (int k = 0; k < 3; k++) begin
            int c, bb;
            c  = int'(cw[8*k +: 8]);
            bb = int'(b[8*k +: 8]);
            if (a == 255)      r[8*k +: 8] = 8'(c);
            else if (a == 0)   r[8*k +: 8] = 8'(bb);
            else               r[8*k +: 8] = 8'((c * a + bb * (256 - a)) / 256);
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_on = 0; m_pend = 0; m_img = 0; p_en = 0;
            p_x = 0; p_y = 0; p_w = 0; p_h = 0;
            l_x = 0; l_y = 0; l_w = 0; l_h = 0; l_rw = 0; l_rh = 0;
            s_v = 0; s_hit = 0; o_v = 0; s_base = '0; o_pix = '0; s_cur = '0;
        end else begin
            o_v   = s_v;
            o_pix = s_hit ? mblend(s_cur, s_base) : s_base;
            s_v    = px_valid;
            s_base = px_base;
            s_hit  = m_on && px_valid && int'(px_x) >= l_x && int'(px_x) < l_x + l_w &&
                     int'(px_y) >= l_y && int'(px_y) < l_y + l_h;
            s_cur  = s_hit ? mmem[((int'(px_y) - l_y) * l_w + (int'(px_x) - l_x)) % 2048] : '0;
            mw = int'(size_data[15:0]);
            mh = int'(size_data[31:16]);
            m_ok     = !(mw > 64 || mh > 64 || (mw > 32 && mh > 32));
            m_any    = pos_wr || en_wr || (size_wr && m_ok);
            m_kill   = size_wr && m_ok && (mw == 0 || mh == 0 || mw != l_rw || mh != l_rh);
            m_commit = frame_done && m_pend;
            if (m_commit) begin
                m_on = p_en && m_img && p_w != 0 && p_h != 0;
                l_x = p_x; l_w = p_w; l_rw = p_w; l_rh = p_h;
                l_y = interlace ? p_y / 2 : p_y;
                l_h = interlace ? p_h / 2 : p_h;
                m_pend = m_any;
            end else begin
                m_pend = m_pend || m_any;
            end
            if (m_kill) m_on = 0;
            if (pos_wr) begin p_x = int'(pos_data[15:0]); p_y = int'(pos_data[31:16]); end
            if (size_wr && m_ok) begin p_w = mw; p_h = mh; end
            if (en_wr) p_en = en_data;
            if (m_kill) m_img = 0; else if (pix_we) m_img = 1;
            if (pix_we)
                mmem[pix_addr] = {pix_wdata[31:24], pix_wdata[7:0], pix_wdata[15:8], pix_wdata[23:16]};
        end
    end

    // ---------------- checking ----------------
    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n)
            chk(out_valid === o_v && cursor_on === m_on && upd_pending === m_pend &&
                (!o_v || out_pix === o_pix), phase, "cycle compare {valid,on,pend,pix}",
                {5'd0, out_valid, cursor_on, upd_pending, out_pix},
                {5'd0, o_v, m_on, m_pend, o_pix});
    end

    // ---------------- stimulus tasks ----------------
    task automatic w_pos(int x, int y);
        pos_data = {16'(y), 16'(x)}; pos_wr = 1'b1;
        @(negedge clk); pos_wr = 1'b0;
    endtask

    task automatic w_size(int w, int h);
        size_data = {16'(h), 16'(w)}; size_wr = 1'b1;
        @(negedge clk); size_wr = 1'b0;
    endtask

    task automatic w_en(bit e);
        en_data = e; en_wr = 1'b1;
        @(negedge clk); en_wr = 1'b0;
    endtask

    task automatic w_pix(int a, logic [31:0] d);
        pix_addr = 11'(a); pix_wdata = d; pix_we = 1'b1;
        @(negedge clk); pix_we = 1'b0;
    endtask

    task automatic fdone();
        frame_done = 1'b1;
        @(negedge clk); frame_done = 1'b0;
    endtask

    task automatic probe(int x, int y, logic [23:0] base, logic [23:0] exp, string req);
        px_valid = 1'b1; px_x = 16'(x); px_y = 16'(y); px_base = base;
        @(negedge clk); px_valid = 1'b0;
        @(negedge clk);
        chk(out_valid === 1'b1 && out_pix === exp, req, "probe pixel", {8'd0, out_pix}, {8'd0, exp});
    endtask

    task automatic scan(int x0, int x1, int y0, int y1);
        for (int y = y0; y <= y1; y++)
            for (int x = x0; x <= x1; x++) begin
                px_valid = 1'b1; px_x = 16'(x); px_y = 16'(y);
                px_base = 24'(x * 5 + y * 977);
                @(negedge clk);
            end
        px_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic state_chk(bit on, bit pend, string req);
        chk(cursor_on === on && upd_pending === pend, req, "state {on,pend}",
            {30'd0, cursor_on, upd_pending}, {30'd0, on, pend});
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    // ---------------- main sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cursor_on === 1'b0 && upd_pending === 1'b0 && out_valid === 1'b0, "R1",
            "reset outputs", {29'd0, cursor_on, upd_pending, out_valid}, 32'd0);

        phase = "R2";
        probe(3, 4, 24'hABCDEF, 24'hABCDEF, "R2");
        scan(0, 9, 0, 2);

        phase = "R10";
        for (int i = 0; i < 2048; i++)
            w_pix(i, 32'h9E3779B9 * 32'(i + 1));

        // small cursor 4x3 at (10,5)
        phase = "R3";
        w_size(4, 3);
        w_pix(0, 32'hFF112233);
        w_pix(1, 32'h00FFFFFF);
        w_pix(2, 32'h80FF0000);
        w_pix(3, 32'h40102030);
        w_pos(10, 5);
        w_en(1'b1);
        state_chk(1'b0, 1'b1, "R3");
        probe(10, 5, 24'h000000, 24'h000000, "R3");
        phase = "R4";
        fdone();
        state_chk(1'b1, 1'b0, "R4");
        phase = "R8";
        probe(10, 5, 24'h445566, 24'h332211, "R8");
        phase = "R9";
        probe(11, 5, 24'h123456, 24'h123456, "R9");
        probe(12, 5, 24'h000000, 24'h00007F, "R9");
        probe(13, 5, 24'h808080, 24'h6C6864, "R9");
        probe(14, 5, 24'h0F0F0F, 24'h0F0F0F, "R2");
        scan(8, 15, 4, 8);

        // wide cursor 64x32 at (100,40), crosses the bank split
        phase = "R6";
        w_size(64, 32);
        state_chk(1'b0, 1'b1, "R6");
        w_pix(1100, 32'hFF0A0B0C);
        w_pix(2047, 32'hFFAABBCC);
        w_pix(0, 32'hFF102030);
        w_pos(100, 40);
        phase = "R10";
        fdone();
        state_chk(1'b1, 1'b0, "R4");
        probe(112, 57, 24'h000000, 24'h0C0B0A, "R10");
        probe(163, 71, 24'h000000, 24'hCCBBAA, "R10");
        probe(100, 40, 24'h000000, 24'h302010, "R10");
        scan(98, 165, 55, 57);

        // rejected sizes
        phase = "R5";
        w_size(40, 40);
        state_chk(1'b1, 1'b0, "R5");
        w_size(70, 1);
        state_chk(1'b1, 1'b0, "R5");
        probe(112, 57, 24'h000000, 24'h0C0B0A, "R5");

        // move takes effect at frame-done only
        phase = "R3";
        w_pos(200, 40);
        state_chk(1'b1, 1'b1, "R3");
        probe(112, 57, 24'h000000, 24'h0C0B0A, "R3");
        fdone();
        state_chk(1'b1, 1'b0, "R3");
        probe(212, 57, 24'h000000, 24'h0C0B0A, "R3");
        probe(112, 57, 24'h010203, 24'h010203, "R3");

        // disable waits for frame-done
        phase = "R11";
        w_en(1'b0);
        state_chk(1'b1, 1'b1, "R11");
        fdone();
        state_chk(1'b0, 1'b0, "R11");
        probe(212, 57, 24'h010203, 24'h010203, "R11");
        w_en(1'b1);
        fdone();
        state_chk(1'b1, 1'b0, "R4");

        // zero dimension blanks at once and stays off after commit
        phase = "R6";
        w_size(0, 5);
        state_chk(1'b0, 1'b1, "R6");
        fdone();
        state_chk(1'b0, 1'b0, "R4");

        // interlaced commit halves y and height
        phase = "R7";
        w_size(8, 8);
        w_pix(0, 32'hFF445566);
        w_pix(24, 32'hFF778899);
        w_pos(50, 20);
        interlace = 1'b1;
        fdone();
        interlace = 1'b0;
        state_chk(1'b1, 1'b0, "R7");
        probe(50, 10, 24'h000000, 24'h665544, "R7");
        probe(50, 13, 24'h000000, 24'h998877, "R7");
        probe(50, 14, 24'h0A0A0A, 24'h0A0A0A, "R7");
        probe(50, 20, 24'h0B0B0B, 24'h0B0B0B, "R7");
        scan(48, 59, 9, 15);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule